// File: doc/BRIEF.md
# Fan Speed and Duty Controller with I2C Register Access

This block lets a host on a two-wire serial bus manage up to three cooling fans. It answers at a fixed 7-bit bus address. It holds an enable bit and a duty setting for each fan, and it drives one pulse-width output per fan. It also counts tachometer pulses over a one-second gate and reports the speed of each fan in revolutions per second.

Register offsets 0 to 3 mean different things for writes and for reads. Offset 0 is the enable register in both directions. Offsets 1 to 3 take a duty in percent when written and return the measured speed when read. A transfer sends a one-byte register pointer first and then data bytes. A read uses a repeated START after the pointer byte. The pointer steps forward by one after every data byte, in both writes and reads.

Both bus lines are open-drain. The block never drives SCL. It only asks for SDA to be pulled low, through `sda_oe_o`.

Top module: `fan_ctrl_top`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal DEV_ADDR (default 0x74). The address byte's LSB is 0 for a write and 1 for a read. A transfer to any other address gets no acknowledge and changes no register.
- R2: In a write, the first byte after the address sets the register pointer and each following byte is written at the pointer. The pointer increments after every data byte in both writes and reads, so a read continues at the pointer that the last write left.
- R3: Writing offset 0 stores data bits 2:0 as the enables of fans 1 to 3, with bit 0 for fan 1, and ignores bits 7:3. Reading offset 0 returns the enables in bits 2:0 and zeros above them. After reset the enables are 3'b111.
- R4: Each duty register resets to 30. The PWM period is 100 steps of PWM_DIV clocks each, and a duty of N gives N×PWM_DIV high clocks in each period.
- R5: A duty write above 100 is stored as 100. A duty of 0 keeps the output low at all times, and a duty of 100 keeps an enabled output high at all times.
- R6: A fan whose enable bit is 0 keeps its PWM output low, whatever its duty register holds.
- R7: Each tach input is synchronized and its falling edges are counted over a gate of CLK_HZ clocks. At the end of each gate the count divided by TACH_PPR (default 2) is latched as the speed. Between gate ends the speed value does not change.
- R8: A speed above 255 is reported as 255.
- R9: Reading offsets 1 to 3 returns the speeds of fans 1 to 3. Duty writes to those offsets leave the speed values that are read unchanged.
- R10: Offsets above 3 read as 0x00, and writes to them change no register.
- R11: The block pulls SDA low only to acknowledge a byte or to send a read data bit. It releases SDA at a STOP and whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; also the time base for the tach gate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| tach_i | input | 3 | Tachometer pulse inputs, bit 0 for fan 1 |
| pwm_o | output | 3 | PWM drive outputs, bit 0 for fan 1 |

## Verification
A wrong register pointer shows up in the very next byte that is read back. An off-by-one in the pointer increment is caught by multi-byte reads and writes. A fault in the step counter, the prescaler or the enable gating changes the number of high clocks that `pwm_o` shows within one PWM period of a write. Tach edges that are lost or counted twice, or a wrong gate length, alter the speed value one gate later. The tach periods are chosen so that the alignment of the gate cannot change the expected value. A fault in the bus engine shows as a missing or unexpected acknowledge on the very byte where it happens. The suspicious cases get directed checks: offsets outside the map, a foreign bus address, clamping, and saturation.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int NFAN      = 3;
  localparam int DUTY_MAX  = 100;
  localparam int DUTY_RST  = 30;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_DEV_ACK, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK
  } i2c_st_e;
endpackage

// File: rtl/i2c_target.sv
module i2c_target import fan_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h74
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic       wr_o,
  output logic [7:0] waddr_o,
  output logic [7:0] wdata_o,
  output logic [7:0] rptr_o,
  input  logic [7:0] rdata_i
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;

  i2c_st_e    st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, txsh, ptr;
  logic       first_q, rw_q, nack_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_q    <= scl_sync[1];
      sda_q    <= sda_sync[1];
    end
  end

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txsh    <= '0;
      ptr     <= '0;
      first_q <= 1'b1;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      oe_q    <= 1'b0;
      wr_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      wr_o <= 1'b0;
      if (start_det) begin
        st      <= ST_DEV;
        bitcnt  <= '0;
        oe_q    <= 1'b0;
        first_q <= 1'b1;
      end else if (stop_det) begin
        st   <= ST_IDLE;
        oe_q <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_RX: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (st == ST_DEV) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  st   <= ST_DEV_ACK;
                  oe_q <= 1'b1;
                  rw_q <= shreg[0];
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                st   <= ST_RX_ACK;
                oe_q <= 1'b1;
                if (first_q) begin
                  ptr     <= shreg;
                  first_q <= 1'b0;
                end else begin
                  wr_o    <= 1'b1;
                  waddr_o <= ptr;
                  wdata_o <= shreg;
                  ptr     <= ptr + 8'd1;
                end
              end
            end
          end
          ST_DEV_ACK: if (scl_fall) begin
            bitcnt <= '0;
            if (rw_q) begin
              st   <= ST_TX;
              txsh <= rdata_i;
              oe_q <= ~rdata_i[7];
              ptr  <= ptr + 8'd1;
            end else begin
              st   <= ST_RX;
              oe_q <= 1'b0;
            end
          end
          ST_RX_ACK: if (scl_fall) begin
            st     <= ST_RX;
            oe_q   <= 1'b0;
            bitcnt <= '0;
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                st   <= ST_TX_ACK;
                oe_q <= 1'b0;
              end else begin
                txsh <= {txsh[6:0], 1'b0};
                oe_q <= ~txsh[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              nack_q <= sda_s;
            end else if (scl_fall) begin
              if (!nack_q) begin
                st     <= ST_TX;
                bitcnt <= '0;
                txsh   <= rdata_i;
                oe_q   <= ~rdata_i[7];
                ptr    <= ptr + 8'd1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
  assign rptr_o   = ptr;

  // R11
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
  // R11
  oe_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && scl_q && !start_det && !stop_det) |=> $stable(sda_oe_o));
  // R2
  wr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (st == ST_RX_ACK));
endmodule

// File: rtl/fan_pwm.sv
module fan_pwm import fan_pkg::*; #(
  parameter int PWM_DIV = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [6:0] duty_i,
  output logic       pwm_o
);
  localparam int PW = (PWM_DIV > 1) ? $clog2(PWM_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [6:0]    step_q;
  logic          tick;

  assign tick = (pre_q == PW'(PWM_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      step_q <= '0;
      pwm_o  <= 1'b0;
    end else begin
      pre_q <= tick ? '0 : pre_q + PW'(1);
      if (tick) step_q <= (step_q == 7'(DUTY_MAX - 1)) ? 7'd0 : step_q + 7'd1;
      pwm_o <= en_i && (step_q < duty_i);
    end
  end

  // R6
  dis_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o);
  // R5
  zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_i == 7'd0) |=> !pwm_o);
  // R5
  full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && duty_i == 7'(DUTY_MAX)) |=> pwm_o);
endmodule

// File: rtl/fan_tach.sv
module fan_tach #(
  parameter int CLK_HZ   = 1_000_000,
  parameter int TACH_PPR = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tach_i,
  output logic [7:0] rps_o
);
  localparam int GW  = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam int CWR = $clog2(CLK_HZ + 2);
  localparam int CW  = (CWR < 9) ? 9 : CWR;

  logic [1:0]    sync_q;
  logic          prev_q, fall;
  logic [GW-1:0] gate_q;
  logic          gate_end;
  logic [CW-1:0] cnt_q, quot;

  assign fall     = prev_q & ~sync_q[1];
  assign gate_end = (gate_q == GW'(CLK_HZ - 1));
  assign quot     = cnt_q / CW'(TACH_PPR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      gate_q <= '0;
      cnt_q  <= '0;
      rps_o  <= '0;
    end else begin
      sync_q <= {sync_q[0], tach_i};
      prev_q <= sync_q[1];
      gate_q <= gate_end ? '0 : gate_q + GW'(1);
      if (gate_end) begin
        cnt_q <= CW'(fall);
        rps_o <= (quot > CW'(255)) ? 8'hFF : quot[7:0];
      end else if (fall) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R7
  rps_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_end |=> $stable(rps_o));
endmodule

// File: rtl/fan_ctrl_top.sv
module fan_ctrl_top import fan_pkg::*; #(
  parameter logic [6:0] DEV_ADDR = 7'h74,
  parameter int CLK_HZ   = 1_000_000,
  parameter int PWM_DIV  = 100,
  parameter int TACH_PPR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe_o,
  input  logic [NFAN-1:0] tach_i,
  output logic [NFAN-1:0] pwm_o
);
  logic            wr;
  logic [7:0]      waddr, wdata, rptr, rdata;
  logic [NFAN-1:0] ctrl_q;
  logic [6:0]      duty_q [NFAN];
  logic [7:0]      rps    [NFAN];

  i2c_target #(.DEV_ADDR(DEV_ADDR)) u_i2c (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_oe_o,
    .wr_o(wr), .waddr_o(waddr), .wdata_o(wdata),
    .rptr_o(rptr), .rdata_i(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '1;
      for (int i = 0; i < NFAN; i++) duty_q[i] <= 7'(DUTY_RST);
    end else if (wr) begin
      if (waddr == 8'd0) ctrl_q <= wdata[NFAN-1:0];
      for (int i = 0; i < NFAN; i++)
        if (waddr == 8'(i + 1))
          duty_q[i] <= (wdata > 8'(DUTY_MAX)) ? 7'(DUTY_MAX) : wdata[6:0];
    end
  end

  // Write and read views of offsets 1..NFAN differ: reads see speed.
  always_comb begin
    rdata = '0;
    if (rptr == 8'd0) rdata = 8'(ctrl_q);
    for (int i = 0; i < NFAN; i++)
      if (rptr == 8'(i + 1)) rdata = rps[i];
  end

  for (genvar g = 0; g < NFAN; g++) begin : g_fan
    fan_pwm #(.PWM_DIV(PWM_DIV)) u_pwm (
      .clk_i, .rst_ni, .en_i(ctrl_q[g]), .duty_i(duty_q[g]), .pwm_o(pwm_o[g])
    );
    fan_tach #(.CLK_HZ(CLK_HZ), .TACH_PPR(TACH_PPR)) u_tach (
      .clk_i, .rst_ni, .tach_i(tach_i[g]), .rps_o(rps[g])
    );
    // R5
    duty_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      duty_q[g] <= 7'(DUTY_MAX));
  end

  // R3
  ctrl_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && waddr == 8'd0) |=> (ctrl_q == $past(wdata[NFAN-1:0])));
endmodule

// File: tb/tb_fan_ctrl_top.sv
module tb_fan_ctrl_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int CLK_HZ     = 2000;
  localparam int PWM_DIV    = 2;
  localparam int PERIOD_CYC = 100 * PWM_DIV;
  localparam int NVEC       = 5;
  // {offset, duty written, expected high clocks per period}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd1, 8'd75,  8'd150},
    {8'd2, 8'd0,   8'd0},
    {8'd3, 8'd100, 8'd200},
    {8'd1, 8'd150, 8'd200},
    {8'd2, 8'd1,   8'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [2:0] tach = '0, pwm;
  int compared = 0, mismatched = 0;
  bit done = 1'b0;

  assign sda_bus = sda_m & ~sda_oe;

  fan_ctrl_top #(.CLK_HZ(CLK_HZ), .PWM_DIV(PWM_DIV), .TACH_PPR(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .tach_i(tach), .pwm_o(pwm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  // fan1 period 96 clk (20-21 falls per gate), fan2 200 clk, fan3 2 clk
  initial begin #7; forever #480 tach[0] = ~tach[0]; end
  initial begin #2; forever #1000 tach[1] = ~tach[1]; end
  initial begin #3; forever #10 tach[2] = ~tach[2]; end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic b_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic b_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask
  task automatic b_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
  endtask
  task automatic b_wbyte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) b_bit(d[i]);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl = 1'b0; wq(Q);
  endtask
  task automatic b_rbyte(input logic last, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); d[i] = sda_bus; wq(Q); scl = 1'b0;
    end
    wq(Q);
    b_bit(last);
  endtask

  task automatic i2c_write(input logic [6:0] dev, input logic [7:0] p, input int n,
                           input logic [7:0] d0, d1, d2, output logic dev_ack);
    logic a;
    b_start();
    b_wbyte({dev, 1'b0}, dev_ack);
    b_wbyte(p, a);
    if (n > 0) b_wbyte(d0, a);
    if (n > 1) b_wbyte(d1, a);
    if (n > 2) b_wbyte(d2, a);
    b_stop();
  endtask

  task automatic i2c_read(input logic [7:0] p, input int n,
                          output logic [7:0] r0, r1, r2);
    logic a;
    r1 = '0; r2 = '0;
    b_start();
    b_wbyte({7'h74, 1'b0}, a);
    b_wbyte(p, a);
    b_start();
    b_wbyte({7'h74, 1'b1}, a);
    b_rbyte(n == 1, r0);
    if (n > 1) b_rbyte(n == 2, r1);
    if (n > 2) b_rbyte(1'b1, r2);
    b_stop();
  endtask

  task automatic hi_count(input int f, output int c);
    c = 0;
    for (int i = 0; i < PERIOD_CYC; i++) begin
      @(negedge clk);
      c += int'(pwm[f]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [7:0] r0, r1, r2, s0, s1, s2;
    logic ack;
    int c;
    wq(5);
    rst_n = 1'b1;
    wq(10);
    // Reset state
    chk("R11 sda released after reset", int'(sda_oe), 0);
    for (int f = 0; f < 3; f++) begin
      hi_count(f, c);
      chk("R4 reset duty 30", c, 30 * PWM_DIV);
    end
    i2c_read(8'd0, 1, r0, r1, r2);
    chk("R3 reset enables", r0, 8'h07);

    // Speed: wait for several full gates
    wq(4 * CLK_HZ);
    i2c_read(8'd1, 3, s0, s1, s2);
    chk("R7 fan1 rps", s0, 10);
    chk("R7 fan2 rps", s1, 5);
    chk("R8 fan3 saturates", s2, 255);
    chk("R2 read autoinc", int'(s1 != 8'd0), 1);

    // Vector table: duty writes and measured high time
    for (int v = 0; v < NVEC; v++) begin
      i2c_write(7'h74, VEC[v][23:16], 1, VEC[v][15:8], 8'd0, 8'd0, ack);
      chk("R1 ack own address", int'(ack), 1);
      wq(PERIOD_CYC);
      hi_count(int'(VEC[v][23:16]) - 1, c);
      chk("R4/R5 duty vector", c, int'(VEC[v][7:0]));
    end

    // R2: write with auto-increment across three duties
    i2c_write(7'h74, 8'd1, 3, 8'd40, 8'd50, 8'd60, ack);
    wq(PERIOD_CYC);
    hi_count(0, c); chk("R2 write autoinc fan1", c, 80);
    hi_count(1, c); chk("R2 write autoinc fan2", c, 100);
    hi_count(2, c); chk("R2 write autoinc fan3", c, 120);

    // R3/R6: disable fan2, upper bits ignored
    i2c_write(7'h74, 8'd0, 1, 8'hFD, 8'd0, 8'd0, ack);
    i2c_read(8'd0, 1, r0, r1, r2);
    chk("R3 enable readback masks 7:3", r0, 8'h05);
    wq(PERIOD_CYC);
    hi_count(1, c); chk("R6 disabled fan low", c, 0);
    hi_count(0, c); chk("R6 enabled fan unaffected", c, 80);

    // R1: foreign address ignored
    i2c_write(7'h75, 8'd0, 1, 8'h00, 8'd0, 8'd0, ack);
    chk("R1 no ack foreign address", int'(ack), 0);
    i2c_read(8'd0, 1, r0, r1, r2);
    chk("R1 foreign write ignored", r0, 8'h05);

    // R10: offsets above 3
    i2c_write(7'h74, 8'd4, 2, 8'h33, 8'h44, 8'd0, ack);
    i2c_read(8'd4, 2, r0, r1, r2);
    chk("R10 offset 4 reads 0", r0, 0);
    chk("R10 offset 5 reads 0", r1, 0);
    i2c_read(8'd0, 1, r0, r1, r2);
    chk("R10 enables untouched", r0, 8'h05);
    hi_count(2, c); chk("R10 fan3 duty untouched", c, 120);

    // R9: speeds unchanged by duty writes
    i2c_read(8'd1, 3, r0, r1, r2);
    chk("R9 fan1 rps after duty write", r0, s0);
    chk("R9 fan2 rps after duty write", r1, s1);
    chk("R9 fan3 rps after duty write", r2, s2);

    wq(4);
    chk("R11 sda released after stop", int'(sda_oe), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule